// File: doc/BRIEF.md
# Priority Pause Frame Receive Parser

This block sits beside a MAC receive datapath and watches the byte stream of each incoming frame. It recognises MAC control pause frames addressed either to the reserved multicast control address or to a programmable station address. From a priority pause frame it extracts an eight-bit priority enable field and eight 16-bit pause quanta. From a classic pause frame it extracts a single quantum, which it spreads over all eight priorities. Once the frame's last byte shows no error, the block hands the fields to the per-priority pause timers with a one-cycle load strobe.

The block also keeps a sticky negotiated flag. The first accepted priority pause frame sets it, and from then on classic pause frames are ignored. Each accepted frame steps a statistic counter. It also raises one of two maskable event pulses, depending on whether any enabled priority carries a non-zero quantum. In half-duplex operation the load strobe is withheld, but the statistic and the events still fire.

Top module: `pfc_rx_parser`

## Requirements
- R1: With `pfc_en_i` low, no frame is accepted (no load, event or statistic change), and `negotiated_o` is cleared on the next clock edge.
- R2: The first six bytes must equal 0x0180C2000001 or `spec_addr_i`, most significant byte first; any other destination is ignored.
- R3: Bytes 12..13 must be 0x8808. Bytes 14..15 select the format: 0x0101 for priority pause, 0x0001 for classic pause. Any other value is ignored.
- R4: For priority pause, byte 17 gives the enable field (bit k for priority k) and bytes 18+2k..19+2k give priority k's quantum, high byte first. The frame must be at least 34 bytes long.
- R5: A classic pause frame of at least 18 bytes loads an enable field of 0xFF, and every priority receives the quantum in bytes 16..17.
- R6: An accepted priority pause frame sets `negotiated_o`. The flag stays set while `pfc_en_i` is high, and while it is set classic pause frames are ignored.
- R7: A frame whose last byte carries `rx_err_i` causes no load, no event, no statistic change and no change to the loaded fields.
- R8: Each accepted frame increments `stat_cnt_o` by exactly one.
- R9: `irq_nz_o` pulses when an enabled priority (all priorities for classic) has a non-zero quantum, gated by `irq_mask_i[0]`. Otherwise `irq_zero_o` pulses, gated by `irq_mask_i[1]`.
- R10: With `full_duplex_i` low, an accepted frame produces no load strobe and leaves the loaded fields unchanged, while R8 and R9 still apply.
- R11: `load_o` and the event outputs are one-cycle pulses, registered two clock edges after the edge that samples the last byte. `load_pev_o` and `load_times_o` hold their values between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Byte strobe |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_err_i | input | 1 | FCS or other error, sampled on last byte |
| pfc_en_i | input | 1 | Pause frame reception enable |
| full_duplex_i | input | 1 | Full-duplex mode; low suppresses loading |
| spec_addr_i | input | 48 | Programmable matching destination address |
| irq_mask_i | input | 2 | Bit0 enables non-zero event, bit1 zero event |
| load_o | output | 1 | Load strobe to pause timers |
| load_pev_o | output | 8 | Loaded priority enable field |
| load_times_o | output | 128 | Loaded quanta, priority k at bits 16k+15:16k |
| negotiated_o | output | 1 | Sticky priority pause negotiated flag |
| stat_cnt_o | output | STAT_W | Accepted pause frame count |
| irq_nz_o | output | 1 | Non-zero quantum event pulse |
| irq_zero_o | output | 1 | Zero quantum event pulse |

## Verification
The bench sends classic frames both before and after negotiation. A design that kept honouring classic frames once negotiated would load all priorities and disturb the statistic. Errored frames, half-duplex mode and short frames are checked against the held load fields, which exposes any design that updates its outputs before the frame is confirmed good. The bench also sends a priority frame whose quanta are non-zero only on disabled priorities, to catch a zero/non-zero split that ignores the enable field. Further checks cover dropping the enable input, which must clear negotiation, and specific-address matching.

// File: rtl/pfc_rx_pkg.sv
package pfc_rx_pkg;
  localparam int NUM_PRIO  = 8;
  localparam int TIME_W    = 16;
  localparam int IDX_W     = 6;
  localparam logic [47:0] RSV_DA    = 48'h0180C2000001;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] OP_PFC    = 16'h0101;
  localparam logic [15:0] OP_CLS    = 16'h0001;
  localparam int IDX_TYPE = 12;
  localparam int IDX_OP   = 14;
  localparam int IDX_PEV  = 16;
  localparam int IDX_TIME = 18;
  localparam int PFC_LEN  = IDX_TIME + 2 * NUM_PRIO;
  localparam int CLS_LEN  = IDX_PEV + 2;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CLS  = 2'd1,
    KIND_PFC  = 2'd2
  } pause_kind_e;
endpackage

// File: rtl/pfc_hdr_match.sv
module pfc_hdr_match
  import pfc_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [47:0]      spec_addr_i,
  output logic             da_ok_o,
  output logic             type_ok_o,
  output logic             op_pfc_o,
  output logic             op_cls_o
);
  logic rsv_q, spec_q, type_q, pfc_q, cls_q;
  logic [7:0] rsv_b, spec_b;

  always_comb begin
    rsv_b  = 8'h00;
    spec_b = 8'h00;
    for (int i = 0; i < 6; i++) begin
      if (idx_i == IDX_W'(i)) begin
        rsv_b  = RSV_DA[8*(5-i) +: 8];
        spec_b = spec_addr_i[8*(5-i) +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsv_q  <= 1'b0;
      spec_q <= 1'b0;
      type_q <= 1'b0;
      pfc_q  <= 1'b0;
      cls_q  <= 1'b0;
    end else if (take_i) begin
      if (idx_i == '0) begin
        rsv_q  <= (byte_i == rsv_b);
        spec_q <= (byte_i == spec_b);
      end else if (idx_i < IDX_W'(6)) begin
        rsv_q  <= rsv_q  & (byte_i == rsv_b);
        spec_q <= spec_q & (byte_i == spec_b);
      end
      if (idx_i == IDX_W'(IDX_TYPE))
        type_q <= (byte_i == CTRL_TYPE[15:8]);
      if (idx_i == IDX_W'(IDX_TYPE + 1))
        type_q <= type_q & (byte_i == CTRL_TYPE[7:0]);
      if (idx_i == IDX_W'(IDX_OP)) begin
        pfc_q <= (byte_i == OP_PFC[15:8]);
        cls_q <= (byte_i == OP_CLS[15:8]);
      end
      if (idx_i == IDX_W'(IDX_OP + 1)) begin
        pfc_q <= pfc_q & (byte_i == OP_PFC[7:0]);
        cls_q <= cls_q & (byte_i == OP_CLS[7:0]);
      end
    end
  end

  assign da_ok_o   = rsv_q | spec_q;
  assign type_ok_o = type_q;
  assign op_pfc_o  = pfc_q;
  assign op_cls_o  = cls_q;
endmodule

// File: rtl/pfc_field_capture.sv
module pfc_field_capture
  import pfc_rx_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 byte_i,
  input  logic                       take_i,
  input  logic [IDX_W-1:0]           idx_i,
  output logic [7:0]                 pev_o,
  output logic [TIME_W-1:0]          cls_time_o,
  output logic [NUM_PRIO*TIME_W-1:0] times_o
);
  logic [7:0] b16_q, b17_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b16_q <= '0;
      b17_q <= '0;
    end else if (take_i) begin
      if (idx_i == IDX_W'(IDX_PEV))     b16_q <= byte_i;
      if (idx_i == IDX_W'(IDX_PEV + 1)) b17_q <= byte_i;
    end
  end

  assign pev_o      = b17_q;
  assign cls_time_o = {b16_q, b17_q};

  for (genvar k = 0; k < NUM_PRIO; k++) begin : g_prio
    localparam int HI = IDX_TIME + 2 * k;
    logic [7:0] hi_q, lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (take_i) begin
        if (idx_i == IDX_W'(HI))     hi_q <= byte_i;
        if (idx_i == IDX_W'(HI + 1)) lo_q <= byte_i;
      end
    end
    assign times_o[k*TIME_W +: TIME_W] = {hi_q, lo_q};
  end
endmodule

// File: rtl/pfc_event_gen.sv
module pfc_event_gen
  import pfc_rx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  pause_kind_e                kind_i,
  input  logic [7:0]                 pev_i,
  input  logic [TIME_W-1:0]          cls_time_i,
  input  logic [NUM_PRIO*TIME_W-1:0] times_i,
  input  logic                       full_duplex_i,
  input  logic                       pfc_en_i,
  input  logic [1:0]                 irq_mask_i,
  output logic                       load_o,
  output logic [7:0]                 load_pev_o,
  output logic [NUM_PRIO*TIME_W-1:0] load_times_o,
  output logic                       negotiated_o,
  output logic [STAT_W-1:0]          stat_cnt_o,
  output logic                       irq_nz_o,
  output logic                       irq_zero_o
);
  logic                       is_pfc, hit;
  logic [7:0]                 pev_sel;
  logic [NUM_PRIO*TIME_W-1:0] time_sel;
  logic [NUM_PRIO-1:0]        live;

  assign is_pfc  = (kind_i == KIND_PFC);
  assign hit     = (kind_i != KIND_NONE);
  assign pev_sel = is_pfc ? pev_i : 8'hFF;

  for (genvar k = 0; k < NUM_PRIO; k++) begin : g_sel
    assign time_sel[k*TIME_W +: TIME_W] = is_pfc ? times_i[k*TIME_W +: TIME_W] : cls_time_i;
    assign live[k] = pev_sel[k] && (time_sel[k*TIME_W +: TIME_W] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_o       <= 1'b0;
      load_pev_o   <= '0;
      load_times_o <= '0;
      negotiated_o <= 1'b0;
      stat_cnt_o   <= '0;
      irq_nz_o     <= 1'b0;
      irq_zero_o   <= 1'b0;
    end else begin
      load_o     <= hit & full_duplex_i;
      irq_nz_o   <= hit & (|live) & irq_mask_i[0];
      irq_zero_o <= hit & ~(|live) & irq_mask_i[1];
      if (hit & full_duplex_i) begin
        load_pev_o   <= pev_sel;
        load_times_o <= time_sel;
      end
      if (hit) stat_cnt_o <= stat_cnt_o + 1'b1;
      if (!pfc_en_i)   negotiated_o <= 1'b0;
      else if (is_pfc) negotiated_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pfc_rx_parser.sv
module pfc_rx_parser
  import pfc_rx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [7:0]                 rx_data_i,
  input  logic                       rx_valid_i,
  input  logic                       rx_sof_i,
  input  logic                       rx_eof_i,
  input  logic                       rx_err_i,
  input  logic                       pfc_en_i,
  input  logic                       full_duplex_i,
  input  logic [47:0]                spec_addr_i,
  input  logic [1:0]                 irq_mask_i,
  output logic                       load_o,
  output logic [7:0]                 load_pev_o,
  output logic [NUM_PRIO*TIME_W-1:0] load_times_o,
  output logic                       negotiated_o,
  output logic [STAT_W-1:0]          stat_cnt_o,
  output logic                       irq_nz_o,
  output logic                       irq_zero_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             in_frame_q, take, last;
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             da_ok, type_ok, op_pfc, op_cls;
  logic [7:0]                 pev;
  logic [TIME_W-1:0]          cls_time;
  logic [NUM_PRIO*TIME_W-1:0] times;
  pause_kind_e      verdict_q, verdict_d;

  assign take    = rx_valid_i & (rx_sof_i | in_frame_q);
  assign last    = take & rx_eof_i;
  assign cur_idx = rx_sof_i ? '0 : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      idx_q      <= '0;
    end else if (take) begin
      in_frame_q <= ~rx_eof_i;
      idx_q      <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
    end
  end

  pfc_hdr_match u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (rx_data_i),
    .take_i     (take),
    .idx_i      (cur_idx),
    .spec_addr_i(spec_addr_i),
    .da_ok_o    (da_ok),
    .type_ok_o  (type_ok),
    .op_pfc_o   (op_pfc),
    .op_cls_o   (op_cls)
  );

  pfc_field_capture u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_i    (rx_data_i),
    .take_i    (take),
    .idx_i     (cur_idx),
    .pev_o     (pev),
    .cls_time_o(cls_time),
    .times_o   (times)
  );

  // header flags are final by the last byte of any frame long enough to qualify
  always_comb begin
    verdict_d = KIND_NONE;
    if (last && !rx_err_i && pfc_en_i && da_ok && type_ok) begin
      if (op_pfc && cur_idx >= IDX_W'(PFC_LEN - 1))
        verdict_d = KIND_PFC;
      else if (op_cls && !negotiated_o && cur_idx >= IDX_W'(CLS_LEN - 1))
        verdict_d = KIND_CLS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) verdict_q <= KIND_NONE;
    else         verdict_q <= verdict_d;
  end

  pfc_event_gen #(.STAT_W(STAT_W)) u_events (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kind_i       (verdict_q),
    .pev_i        (pev),
    .cls_time_i   (cls_time),
    .times_i      (times),
    .full_duplex_i(full_duplex_i),
    .pfc_en_i     (pfc_en_i),
    .irq_mask_i   (irq_mask_i),
    .load_o       (load_o),
    .load_pev_o   (load_pev_o),
    .load_times_o (load_times_o),
    .negotiated_o (negotiated_o),
    .stat_cnt_o   (stat_cnt_o),
    .irq_nz_o     (irq_nz_o),
    .irq_zero_o   (irq_zero_o)
  );
endmodule

// File: rtl/pfc_rx_parser_chk.sv
module pfc_rx_parser_chk #(
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_eof_i,
  input logic              rx_err_i,
  input logic              pfc_en_i,
  input logic              full_duplex_i,
  input logic [1:0]        irq_mask_i,
  input logic              load_o,
  input logic              negotiated_o,
  input logic [STAT_W-1:0] stat_cnt_o,
  input logic              irq_nz_o,
  input logic              irq_zero_o
);
  p_clear_neg_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pfc_en_i) |-> !negotiated_o);

  p_sticky_neg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pfc_en_i) && $past(negotiated_o) |-> negotiated_o);

  p_err_discard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o || irq_nz_o || irq_zero_o) |->
      $past(rx_valid_i && rx_eof_i && !rx_err_i && pfc_en_i, 2));

  p_stat_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_cnt_o != $past(stat_cnt_o) |-> stat_cnt_o == $past(stat_cnt_o) + 1'b1);

  p_irq_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_nz_o && irq_zero_o));

  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_nz_o |-> $past(irq_mask_i[0])) and (irq_zero_o |-> $past(irq_mask_i[1])));

  p_hd_noload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(full_duplex_i));

  p_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

bind pfc_rx_parser pfc_rx_parser_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_eof_i     (rx_eof_i),
  .rx_err_i     (rx_err_i),
  .pfc_en_i     (pfc_en_i),
  .full_duplex_i(full_duplex_i),
  .irq_mask_i   (irq_mask_i),
  .load_o       (load_o),
  .negotiated_o (negotiated_o),
  .stat_cnt_o   (stat_cnt_o),
  .irq_nz_o     (irq_nz_o),
  .irq_zero_o   (irq_zero_o)
);

// File: tb/tb_pfc_rx_parser.sv
`timescale 1ns/1ps
module tb_pfc_rx_parser;
  localparam int STAT_W = 32;
  localparam logic [47:0] RSV = 48'h0180C2000001;
  localparam int K_NONE = 0, K_CLS = 1, K_PFC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic pfc_en = 0, fd = 1;
  logic [47:0] spec = 48'h02AABBCCDDEE;
  logic [1:0] mask = 2'b11;
  logic load, neg, irq_nz, irq_zero;
  logic [7:0] lpev;
  logic [127:0] ltimes;
  logic [STAT_W-1:0] stat;

  always #2.5 clk = ~clk;

  pfc_rx_parser #(.STAT_W(STAT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_err_i(rx_err), .pfc_en_i(pfc_en),
    .full_duplex_i(fd), .spec_addr_i(spec), .irq_mask_i(mask), .load_o(load),
    .load_pev_o(lpev), .load_times_o(ltimes), .negotiated_o(neg), .stat_cnt_o(stat),
    .irq_nz_o(irq_nz), .irq_zero_o(irq_zero)
  );

  int checks = 0, errors = 0;
  logic [7:0] fr [48];
  bit exp_neg = 0;
  logic [STAT_W-1:0] exp_stat = '0;
  logic [7:0] exp_pev = '0;
  logic [127:0] exp_times = '0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op);
    for (int i = 0; i < 48; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < 6; i++) fr[i] = da[8*(5-i) +: 8];
    fr[12] = ty[15:8]; fr[13] = ty[7:0];
    fr[14] = op[15:8]; fr[15] = op[7:0];
  endtask

  task automatic set_time(input int k, input logic [15:0] t);
    fr[18+2*k] = t[15:8]; fr[19+2*k] = t[7:0];
  endtask

  task automatic send(input int len, input bit err);
    for (int i = 0; i < len; i++) begin
      if (i > 0 && $urandom % 8 == 0) begin
        @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0;
      end
      @(negedge clk);
      rx_data = fr[i]; rx_valid = 1; rx_sof = (i == 0);
      rx_eof = (i == len - 1); rx_err = err && (i == len - 1);
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    @(negedge clk);
  endtask

  // hdr: header kind the frame carries (length already sufficient when nonzero)
  task automatic do_frame(input int hdr, input int len, input bit err, input string tag);
    int kind;
    bit nz;
    logic [7:0] pv;
    logic [127:0] tm;
    kind = hdr;
    if (!pfc_en || err) kind = K_NONE;
    if (kind == K_CLS && exp_neg) kind = K_NONE;
    pv = (kind == K_PFC) ? fr[17] : 8'hFF;
    for (int k = 0; k < 8; k++)
      tm[16*k +: 16] = (kind == K_PFC) ? {fr[18+2*k], fr[19+2*k]} : {fr[16], fr[17]};
    nz = 0;
    for (int k = 0; k < 8; k++) if (pv[k] && tm[16*k +: 16] != 0) nz = 1;
    send(len, err);
    if (kind != K_NONE) begin
      exp_stat++;
      if (fd) begin exp_pev = pv; exp_times = tm; end
      if (kind == K_PFC) exp_neg = 1;
    end
    chk(load == (kind != K_NONE && fd), {tag, " R11 load R10"}, load, kind != K_NONE && fd);
    chk(lpev == exp_pev && ltimes == exp_times, {tag, " R4 R5 R7 fields"}, {lpev, ltimes[119:0]}, {exp_pev, exp_times[119:0]});
    chk(stat == exp_stat, {tag, " R8 stat"}, stat, exp_stat);
    chk(neg == exp_neg, {tag, " R6 negotiated"}, neg, exp_neg);
    chk(irq_nz == (kind != K_NONE && nz && mask[0]), {tag, " R9 irq_nz"}, irq_nz, kind != K_NONE && nz && mask[0]);
    chk(irq_zero == (kind != K_NONE && !nz && mask[1]), {tag, " R9 irq_zero"}, irq_zero, kind != K_NONE && !nz && mask[1]);
    @(negedge clk);
    chk(!load && !irq_nz && !irq_zero, {tag, " R11 pulse"}, {load, irq_nz, irq_zero}, 0);
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); pfc_en = v;
    if (!v) exp_neg = 0;
    @(negedge clk); @(negedge clk);
    chk(neg == exp_neg, "R1 enable drop clears", neg, exp_neg);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!load && !neg && stat == 0 && !irq_nz && !irq_zero && ltimes == 0, "reset R11", {load, neg, stat}, 0);
    pfc_en = 1;
    @(negedge clk);

    // R5 classic before negotiation, nonzero
    build(RSV, 16'h8808, 16'h0001); fr[16] = 8'h12; fr[17] = 8'h34;
    do_frame(K_CLS, 20, 0, "R5 classic");
    // R9 classic zero
    build(RSV, 16'h8808, 16'h0001); fr[16] = 0; fr[17] = 0;
    do_frame(K_CLS, 18, 0, "R9 classic zero");
    // R7 errored priority frame
    build(RSV, 16'h8808, 16'h0101); fr[17] = 8'h5A;
    do_frame(K_PFC, 34, 1, "R7 err");
    // R2 specific address, R4 fields, R6 negotiate
    build(spec, 16'h8808, 16'h0101); fr[17] = 8'h05;
    for (int k = 0; k < 8; k++) set_time(k, 16'h1000 + 16'(k));
    do_frame(K_PFC, 34, 0, "R2 R4 pfc spec");
    // R6 classic ignored after negotiation
    build(RSV, 16'h8808, 16'h0001); fr[16] = 8'h77; fr[17] = 8'h88;
    do_frame(K_CLS, 18, 0, "R6 classic after neg");
    // R2 wrong destination
    build(48'h0180C2000002, 16'h8808, 16'h0101);
    do_frame(K_NONE, 34, 0, "R2 bad da");
    // R3 wrong opcode and type
    build(RSV, 16'h8808, 16'h0102);
    do_frame(K_NONE, 34, 0, "R3 bad op");
    build(RSV, 16'h8809, 16'h0101);
    do_frame(K_NONE, 34, 0, "R3 bad type");
    // R4 short frame
    build(RSV, 16'h8808, 16'h0101);
    do_frame(K_NONE, 33, 0, "R4 short");
    // R9 nonzero only on disabled priorities
    build(RSV, 16'h8808, 16'h0101); fr[16] = 8'hFF; fr[17] = 8'h0F;
    for (int k = 0; k < 8; k++) set_time(k, k < 4 ? 16'h0 : 16'h00FF);
    do_frame(K_PFC, 34, 0, "R9 disabled nz");
    // R10 half duplex
    fd = 0;
    build(RSV, 16'h8808, 16'h0101); fr[17] = 8'hFF; set_time(3, 16'h0042);
    do_frame(K_PFC, 36, 0, "R10 half duplex");
    fd = 1;
    // R9 mask
    mask = 2'b00;
    build(RSV, 16'h8808, 16'h0101); fr[17] = 8'h01; set_time(0, 16'h0009);
    do_frame(K_PFC, 34, 0, "R9 masked");
    mask = 2'b11;
    // R1 disable
    set_en(0);
    build(RSV, 16'h8808, 16'h0101);
    do_frame(K_PFC, 34, 0, "R1 disabled");
    set_en(1);
    build(RSV, 16'h8808, 16'h0001); fr[16] = 8'h00; fr[17] = 8'h21;
    do_frame(K_CLS, 18, 0, "R1 R6 classic after re-enable");

    for (int n = 0; n < 400; n++) begin
      int sel, len, hdr;
      bit err;
      logic [47:0] da;
      if ($urandom % 15 == 0) set_en(~pfc_en);
      fd = ($urandom % 5 != 0);
      mask = 2'($urandom);
      da = ($urandom % 2) ? RSV : spec;
      err = ($urandom % 8 == 0);
      sel = $urandom % 10;
      hdr = K_NONE;
      if (sel < 4) begin
        build(da, 16'h8808, 16'h0101);
        for (int k = 0; k < 8; k++) if ($urandom % 3 == 0) set_time(k, 0);
        len = 34 + $urandom % 8; hdr = K_PFC;
      end else if (sel < 7) begin
        build(da, 16'h8808, 16'h0001);
        if ($urandom % 3 == 0) begin fr[16] = 0; fr[17] = 0; end
        len = 18 + $urandom % 10; hdr = K_CLS;
      end else if (sel == 7) begin
        build({da[47:8], da[7:0] ^ 8'h80}, 16'h8808, 16'h0101); len = 34;
      end else if (sel == 8) begin
        build(da, 16'h8808, 16'h0100 + 16'($urandom % 2) * 16'h0002); len = 34;
      end else begin
        build(da, 16'h8808, 16'h0101); len = 18 + $urandom % 16;
      end
      do_frame(hdr, len, err, "rand R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule